// File: doc/BRIEF.md
# Row Cache-Line Offset Remapper

This block translates the cache-line offset of a memory request into the physical column offset that the DRAM row buffer is actually accessed at. A row is divided into a power-of-two number of cache-line columns. Each subarray of each bank has its own stored mapping. Every row inside one subarray shares that mapping. A static profile grades each column of a subarray as fast (strong) or slow (weak). From that profile, the block makes sure that logical offset 0, which is the offset most often touched first after a row is opened, lands on a strong column whenever the subarray has one. This lets a later timing stage access it with a shortened activate-to-access delay.

The mapping is a single swap. Logical offset 0 and the lowest-numbered strong column exchange places, and every other offset passes straight through. The swap target is worked out once, when the profile for a subarray is written through the load port, and is held in a small per-subarray table. The request path is a table read followed by the swap, with no register on it. The result is therefore valid in the same cycle as the request.

Top module: `line_swap_remap`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, every subarray uses the identity mapping (physical offset equals logical offset).
- R2: The subarray of an address is bank × (2^(ROW_W−SA_ROW_BITS)) + (row >> SA_ROW_BITS). Every row that yields the same subarray gets the same mapping.
- R3: In a strength mask, bit i set to 1 means column i is strong. A mask whose bit 0 is 1 produces the identity mapping for that subarray.
- R4: For a mask with bit 0 clear and at least one bit set, let t be the lowest set bit. Logical 0 then maps to t, logical t maps to 0, and every other offset maps to itself.
- R5: A mask with no bit set produces the identity mapping.
- R6: The physical offset follows the request inputs combinationally, within the same cycle and without any clock edge.
- R7: A load is written at the rising clock edge. A request to the same subarray in the cycle of the load still sees the previous mapping, and the new mapping applies from the next cycle.
- R8: A load changes only the subarray named by its bank and row. The mappings of all other subarrays are unchanged.
- R9: For every subarray, the mapping over all offsets is a permutation: each physical offset is produced by exactly one logical offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write a strength profile for one subarray this cycle |
| ld_bank | input | BANK_W | Bank of the subarray being loaded |
| ld_row | input | ROW_W | Any row address inside the subarray being loaded |
| ld_strong | input | 2^COL_W | Strength mask, bit i = 1 when column i is strong |
| rq_bank | input | BANK_W | Bank of the request |
| rq_row | input | ROW_W | Row of the request |
| rq_col | input | COL_W | Logical cache-line offset of the request |
| ph_col | output | COL_W | Physical cache-line offset |

## Verification
The two functions that can meet in one cycle are a profile load and a translation aimed at the same subarray. The bench holds a load for one subarray and a request for offset 0 of that subarray in the same cycle. It reads the physical offset before the edge, where it expects the old swap target. It reads it again after the edge, where it expects the target derived from the new mask. It also probes a neighbouring subarray to confirm that nothing leaked into it. Full sweeps over every subarray, several rows and all offsets compare each result with a lowest-set-bit computation done in the bench. They also collect the produced offsets to confirm that each subarray's mapping is a permutation.

// File: rtl/line_swap_pkg.sv
package line_swap_pkg;

  // Grade of one cache-line column in a subarray's profile.
  typedef enum logic {
    COL_WEAK   = 1'b0,
    COL_STRONG = 1'b1
  } col_grade_e;

  // Bits needed to index n items, never less than one.
  function automatic int width_of(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/lsr_pick.sv
module lsr_pick import line_swap_pkg::*; #(
  parameter  int COL_W = 4,
  localparam int COLS  = 1 << COL_W
) (
  input  logic [COLS-1:0]  strong_mask,
  output logic [COL_W-1:0] first_strong
);

  // Lowest strong column. Yields 0 both when column 0 is strong and when
  // no column is strong, so the swap collapses to the identity there.
  function automatic logic [COL_W-1:0] lowest_strong(input logic [COLS-1:0] m);
    logic [COL_W-1:0] r;
    r = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (col_grade_e'(m[i]) == COL_STRONG) r = COL_W'(i);
    end
    return r;
  endfunction

  assign first_strong = lowest_strong(strong_mask);

endmodule

// File: rtl/lsr_table.sv
module lsr_table #(
  parameter  int ENTRIES = 16,
  parameter  int IDX_W   = 4,
  parameter  int COL_W   = 4,
  localparam int COLS    = 1 << COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [COL_W-1:0] wr_tgt,
  input  logic [COLS-1:0]  wr_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [COL_W-1:0] rd_tgt
);

  logic [COL_W-1:0]   ent_q [ENTRIES];
  logic [ENTRIES-1:0] wr_hit;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    assign wr_hit[k] = wr_en && (int'(wr_idx) == k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q[k] <= '0;
      else if (wr_hit[k]) ent_q[k] <= wr_tgt;
    end

    // R3 R5: stored target names a strong column, or 0 for an empty mask
    p_target_strong_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (((($past(wr_mask) >> ent_q[k]) & COLS'(1)) != '0) ||
                    (($past(wr_mask) == '0) && (ent_q[k] == '0))));

    // R4: no strong column lies below the stored target
    p_lowest_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (($past(wr_mask) & ((COLS'(1) << ent_q[k]) - COLS'(1))) == '0));

    // R8: entries not addressed by a load keep their value
    p_untouched_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[k] |=> $stable(ent_q[k]));
  end

  // Out-of-range slots (bank beyond BANKS) read as the identity.
  assign rd_tgt = (int'(rd_idx) < ENTRIES) ? ent_q[rd_idx] : '0;

endmodule

// File: rtl/lsr_xlate.sv
module lsr_xlate #(
  parameter int COL_W = 4
) (
  input  logic [COL_W-1:0] lane_in,
  input  logic [COL_W-1:0] swap_tgt,
  output logic [COL_W-1:0] lane_out
);

  // Exchange lane 0 with the target lane; pass all others through.
  function automatic logic [COL_W-1:0] swap_lane(input logic [COL_W-1:0] l,
                                                 input logic [COL_W-1:0] t);
    if (l == '0) return t;
    if (l == t)  return '0;
    return l;
  endfunction

  assign lane_out = swap_lane(lane_in, swap_tgt);

endmodule

// File: rtl/line_swap_remap.sv
module line_swap_remap import line_swap_pkg::*; #(
  parameter  int BANKS       = 4,
  parameter  int ROW_W       = 10,
  parameter  int SA_ROW_BITS = 8,
  parameter  int COL_W       = 4,
  localparam int BANK_W      = width_of(BANKS),
  localparam int SA_SEL_W    = ROW_W - SA_ROW_BITS,
  localparam int SA_PER_BANK = 1 << SA_SEL_W,
  localparam int ENTRIES     = BANKS * SA_PER_BANK,
  localparam int IDX_W       = width_of(ENTRIES),
  localparam int COLS        = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [COLS-1:0]   ld_strong,
  input  logic [BANK_W-1:0] rq_bank,
  input  logic [ROW_W-1:0]  rq_row,
  input  logic [COL_W-1:0]  rq_col,
  output logic [COL_W-1:0]  ph_col
);

  // Flat subarray slot from bank and the row bits above one subarray.
  function automatic logic [IDX_W-1:0] sa_slot(input logic [BANK_W-1:0] b,
                                               input logic [ROW_W-1:0]  r);
    return IDX_W'(b) * IDX_W'(SA_PER_BANK) + IDX_W'(r >> SA_ROW_BITS);
  endfunction

  logic [IDX_W-1:0] ld_slot;
  logic [IDX_W-1:0] rq_slot;
  logic [COL_W-1:0] pick_tgt;
  logic [COL_W-1:0] cur_tgt;

  assign ld_slot = sa_slot(ld_bank, ld_row);
  assign rq_slot = sa_slot(rq_bank, rq_row);

  lsr_pick #(.COL_W(COL_W)) u_pick (
    .strong_mask  (ld_strong),
    .first_strong (pick_tgt)
  );

  lsr_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .COL_W   (COL_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_en),
    .wr_idx  (ld_slot),
    .wr_tgt  (pick_tgt),
    .wr_mask (ld_strong),
    .rd_idx  (rq_slot),
    .rd_tgt  (cur_tgt)
  );

  lsr_xlate #(.COL_W(COL_W)) u_xlate (
    .lane_in  (rq_col),
    .swap_tgt (cur_tgt),
    .lane_out (ph_col)
  );

  // R4: logical 0 lands on the stored swap target
  p_zero_to_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_col == '0) |-> (ph_col == cur_tgt));

  // R9: the target lane takes the place of lane 0
  p_target_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_col == cur_tgt) |-> (ph_col == '0));

  // R9: lanes outside the swapped pair are untouched
  p_rest_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rq_col != '0) && (rq_col != cur_tgt)) |-> (ph_col == rq_col));

endmodule

// File: tb/line_swap_remap_bench.sv
module line_swap_remap_bench;
  localparam int CLK_P  = 10;
  localparam int NSLOT  = 16;
  localparam int NCOL   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_bank = '0;
  logic [9:0]  ld_row = '0;
  logic [15:0] ld_strong = '0;
  logic [1:0]  rq_bank = '0;
  logic [9:0]  rq_row = '0;
  logic [3:0]  rq_col = '0;
  logic [3:0]  ph_col;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] model [NSLOT];

  always #(CLK_P/2) clk = ~clk;

  line_swap_remap u_line_swap_remap (
    .clk (clk), .rst_n (rst_n),
    .ld_en (ld_en), .ld_bank (ld_bank), .ld_row (ld_row), .ld_strong (ld_strong),
    .rq_bank (rq_bank), .rq_row (rq_row), .rq_col (rq_col), .ph_col (ph_col)
  );

  // Expected physical offset: isolate the lowest set bit arithmetically.
  function automatic int expect_col(int col, logic [15:0] m);
    logic [15:0] iso;
    int t;
    if (m == 16'h0 || m[0]) return col;
    iso = m & (~m + 16'h1);
    t = 0;
    for (int j = 0; j < NCOL; j++) if (iso == (16'h1 << j)) t = j;
    if (col == 0) return t;
    if (col == t) return 0;
    return col;
  endfunction

  function automatic logic [15:0] mask_gen(int k, int round);
    logic [15:0] m;
    m = 16'((k + 1) * 12059) ^ 16'(round * 20951);
    m[0] = (k % 5 == 4);
    if (k == 0) m = (round == 0) ? 16'h0000 : 16'h8000;
    if (k == 1) m = 16'hFFFF;
    if (k == 2) m = 16'h0001;
    if (k == 3) m = 16'h4000;
    return m;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_rq(int k, int rowoff, int col);
    rq_bank = 2'(k / 4);
    rq_row  = 10'(((k % 4) << 8) | rowoff);
    rq_col  = 4'(col);
  endtask

  task automatic load(int k, logic [15:0] m);
    @(negedge clk);
    ld_en = 1'b1;
    ld_bank = 2'(k / 4);
    ld_row = 10'(((k % 4) << 8) | 8'h37);
    ld_strong = m;
    @(posedge clk);
    #1;
    ld_en = 1'b0;
    model[k] = m;
  endtask

  // Full sweep: each slot, three rows, all offsets, plus permutation check.
  task automatic sweep(string req);
    for (int k = 0; k < NSLOT; k++) begin
      for (int r = 0; r < 3; r++) begin
        logic [15:0] seen;
        int rowoff;
        seen = '0;
        rowoff = (r == 0) ? 0 : ((r == 1) ? 8'h9A : 8'hFF);
        for (int c = 0; c < NCOL; c++) begin
          @(negedge clk);
          set_rq(k, rowoff, c);
          #1;
          chk(req, int'(ph_col), expect_col(c, model[k]), "R2 R4 mapping");
          seen[ph_col] = 1'b1;
          if (c == 0 && model[k] != 16'h0)
            chk("R4", int'(model[k][ph_col]), 1, "offset 0 on strong column");
        end
        chk("R9", int'(seen), 16'hFFFF, "permutation coverage");
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSLOT; k++) model[k] = '0;
    // R1: identity while held in reset
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCOL; c++) begin
      set_rq(6, 0, c);
      #1;
      chk("R1", int'(ph_col), c, "identity in reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    // R3 R4 R5 R2: load every slot, then sweep
    for (int k = 0; k < NSLOT; k++) load(k, mask_gen(k, 0));
    sweep("R4");

    // R8: reload one slot, neighbours keep their mapping
    load(9, 16'h0100);
    for (int k = 8; k <= 10; k += 2) begin
      @(negedge clk);
      set_rq(k, 5, 0);
      #1;
      chk("R8", int'(ph_col), expect_col(0, model[k]), "neighbour unchanged");
    end
    @(negedge clk);
    set_rq(9, 5, 0);
    #1;
    chk("R4", int'(ph_col), 8, "reloaded slot");

    // R6: combinational change within one cycle
    @(negedge clk);
    set_rq(9, 0, 8);
    #1;
    chk("R6", int'(ph_col), 0, "same-cycle lane 8");
    set_rq(9, 0, 3);
    #1;
    chk("R6", int'(ph_col), 3, "same-cycle lane 3");

    // R7: load and request of the same slot in the same cycle
    @(negedge clk);
    ld_en = 1'b1;
    ld_bank = 2'(9 / 4);
    ld_row = 10'(((9 % 4) << 8) | 8'hC0);
    ld_strong = 16'h0A00;
    set_rq(9, 3, 0);
    #1;
    chk("R7", int'(ph_col), 8, "old mapping before edge");
    @(posedge clk);
    #1;
    ld_en = 1'b0;
    model[9] = 16'h0A00;
    chk("R7", int'(ph_col), 9, "new mapping after edge");
    set_rq(9, 3, 9);
    #1;
    chk("R7", int'(ph_col), 0, "new target swaps back");
    set_rq(9, 3, 8);
    #1;
    chk("R7", int'(ph_col), 8, "old target released");

    // second round of masks, including a top-bit-only mask in slot 0
    for (int k = 0; k < NSLOT; k++) load(k, mask_gen(k, 1));
    sweep("R5");

    // R1: reset mid-run restores identity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < NCOL; c++) begin
      set_rq(0, 0, c);
      #1;
      chk("R1", int'(ph_col), c, "identity after mid-run reset");
    end
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule